// File: doc/BRIEF.md
# Power-Up Regulator Sequencer

This block brings up a set of three switching regulators and a charge pump in a fixed, configurable order once supply power is good. A two-bit select code, the digitised form of a three-level strap, and a mode strap are sampled once at the start of each power-up. Sampling happens when the supply-good flag rises or when the external reset input is released. These two values then decide which regulators start and in which order. The charge pump starts first. After a settling interval the first regulator group turns on, and after a further gap the second group follows. Regulators B and C always switch as a pair.

An active-low reset output is released a fixed interval after the start of each sequence, whatever the select code is. The external reset input is active high. It is synchronised and deglitched, and while it is asserted the sequencer drops every output and returns to idle. Per-channel off bits hold individual regulators off at any time. The channel C bit has no effect when the captured mode is high, because B and C then work as one paralleled output. All delays are counted in system clock cycles, and the sequencer state is brought out on a debug port.

Top module: `pwr_seq_top`

## Requirements
- R1: While `rst_n` is low, `cp_en`, `reg_en` and `rst_out_n` are 0 and `dbg_state` is 0 (idle).
- R2: `ext_rst_in` passes a two-stage synchroniser and is accepted only after it has held a new level for DEGLITCH_CYC consecutive cycles; shorter pulses change no output.
- R3: While the filtered external reset is high or the synchronised `supply_ok` is low, the sequencer is idle and all outputs are 0. Idle is reached three cycles after `supply_ok` falls, or DEGLITCH_CYC+3 cycles after `ext_rst_in` rises.
- R4: `sel_code` and `par_mode` are captured on the start cycle S, the first cycle that leaves idle. Later changes have no effect until the next start.
- R5: `cp_en` rises on cycle S, and the first group is enabled on cycle S+CP_SETTLE_CYC.
- R6: `sel_code[1]`=1 (strap open): A is enabled first and B, C follow GROUP_GAP_CYC cycles later, for either value of `par_mode`.
- R7: `sel_code`=2'b01 (pulled down) with `par_mode`=1: B and C are enabled first and A follows GROUP_GAP_CYC cycles later. With `par_mode`=0, no regulator is enabled.
- R8: `sel_code`=2'b00 (grounded): no regulator is enabled.
- R9: `rst_out_n` goes high on cycle S+RST_HOLD_CYC for every select code and stays high until the next return to idle.
- R10: Outside idle, `cp_en` = `sleep_n` OR any `reg_en`. During the settling interval it is also forced high when the captured straps enable some group. Changes of `sleep_n` show on `cp_en` one cycle later.
- R11: `chan_off[i]`=1 holds `reg_en[i]` low (bit 0=A, 1=B, 2=C), taking effect one cycle after the change. `chan_off[2]` is ignored when the captured `par_mode` is 1.
- R12: B and C are switched on in the same cycle whenever neither is held off.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| supply_ok | input | 1 | Supply above its start threshold (asynchronous) |
| ext_rst_in | input | 1 | External reset request, active high (asynchronous) |
| sel_code | input | 2 | Digitised strap: 00 ground, 01 pulled down, 1x open |
| par_mode | input | 1 | Mode strap, 1 = B and C paralleled |
| sleep_n | input | 1 | Active-low sleep |
| chan_off | input | 3 | Per-regulator off bits, [0]=A [1]=B [2]=C |
| cp_en | output | 1 | Charge pump enable |
| reg_en | output | 3 | Regulator enables, [0]=A [1]=B [2]=C |
| rst_out_n | output | 1 | Active-low system reset output |
| dbg_state | output | 2 | Sequencer state: 0 idle, 1 settling, 2 first group, 3 both groups |

## Verification
Every output is registered, so each result is tied to a known cycle. The start cycle S falls three cycles after `supply_ok` rises, or DEGLITCH_CYC+3 cycles after `ext_rst_in` falls. Group one follows at S+CP_SETTLE_CYC, group two at S+CP_SETTLE_CYC+GROUP_GAP_CYC, and the reset release at S+RST_HOLD_CYC. Changes of `chan_off` and `sleep_n` appear one cycle after they are driven. The bench converts each stimulus into a list of output-vector changes stamped with these absolute cycle numbers. A monitor then requires every observed change to match the next stamped entry in both value and cycle, and it treats any change with no pending entry as an error. This covers glitch rejection and strap changes made after capture.

// File: rtl/pwr_seq_pkg.sv
package pwr_seq_pkg;

  localparam int unsigned NUM_REG = 3;
  localparam int unsigned CH_A    = 0;
  localparam int unsigned CH_B    = 1;
  localparam int unsigned CH_C    = 2;

  typedef enum logic [1:0] {
    ST_IDLE    = 2'd0,
    ST_SETTLE  = 2'd1,
    ST_FIRST   = 2'd2,
    ST_BOTH    = 2'd3
  } seq_state_e;

  // Captured strap configuration: sel in [2:1], mode in [0]
  typedef struct packed {
    logic [1:0] sel;
    logic       par_mode;
  } seq_cfg_t;

  // Regulators enabled by the first group
  function automatic logic [NUM_REG-1:0] first_group(seq_cfg_t c);
    logic [NUM_REG-1:0] g;
    g = '0;
    if (c.sel[1]) begin
      g[CH_A] = 1'b1;
    end else if (c.sel[0] && c.par_mode) begin
      g[CH_B] = 1'b1;
      g[CH_C] = 1'b1;
    end
    return g;
  endfunction

  // Regulators enabled by the second group
  function automatic logic [NUM_REG-1:0] second_group(seq_cfg_t c);
    logic [NUM_REG-1:0] g;
    g = '0;
    if (c.sel[1]) begin
      g[CH_B] = 1'b1;
      g[CH_C] = 1'b1;
    end else if (c.sel[0] && c.par_mode) begin
      g[CH_A] = 1'b1;
    end
    return g;
  endfunction

endpackage

// File: rtl/pwr_seq_sync.sv
module pwr_seq_sync #(
  parameter int unsigned W      = 1,
  parameter int unsigned STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [W-1:0] stg_q [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < int'(STAGES); i++) stg_q[i] <= RST_VAL;
    end else begin
      stg_q[0] <= d;
      for (int i = 1; i < int'(STAGES); i++) stg_q[i] <= stg_q[i-1];
    end
  end

  assign q = stg_q[STAGES-1];

endmodule

// File: rtl/pwr_seq_deglitch.sv
module pwr_seq_deglitch #(
  parameter int unsigned HOLD    = 625,
  parameter logic        RST_LVL = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic dout
);

  localparam int unsigned CW = $clog2(HOLD + 1);

  logic          filt_q, filt_d;
  logic [CW-1:0] cnt_q, cnt_d;

  // Next-state: count cycles of disagreement, flip after HOLD of them
  always_comb begin
    filt_d = filt_q;
    cnt_d  = '0;
    if (din != filt_q) begin
      if (cnt_q == CW'(HOLD - 1)) begin
        filt_d = din;
      end else begin
        cnt_d = cnt_q + CW'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      filt_q <= RST_LVL;
      cnt_q  <= '0;
    end else begin
      filt_q <= filt_d;
      cnt_q  <= cnt_d;
    end
  end

  assign dout = filt_q;

endmodule

// File: rtl/pwr_seq_ctrl.sv
module pwr_seq_ctrl
  import pwr_seq_pkg::*;
#(
  parameter int unsigned CP_SETTLE_CYC = 1250000,
  parameter int unsigned GROUP_GAP_CYC = 200000,
  parameter int unsigned RST_HOLD_CYC  = 37500000
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               run,
  input  logic [1:0]         sel_code,
  input  logic               par_mode,
  input  logic               sleep_n,
  input  logic [NUM_REG-1:0] chan_off,
  output logic               cp_en,
  output logic [NUM_REG-1:0] reg_en,
  output logic               rst_out_n,
  output seq_state_e         state,
  output seq_cfg_t           cfg
);

  localparam int unsigned SEQ_MAX = (CP_SETTLE_CYC > GROUP_GAP_CYC) ? CP_SETTLE_CYC : GROUP_GAP_CYC;
  localparam int unsigned SW      = $clog2(SEQ_MAX + 1);
  localparam int unsigned RW      = $clog2(RST_HOLD_CYC + 1);

  seq_state_e         st_q, st_d;
  seq_cfg_t           cfg_q, cfg_d;
  logic [SW-1:0]      seq_cnt_q, seq_cnt_d;
  logic [RW-1:0]      hold_cnt_q, hold_cnt_d;
  logic               rel_q, rel_d;
  logic               cp_q, cp_d;
  logic [NUM_REG-1:0] reg_q, reg_d;

  logic [NUM_REG-1:0] grp1, grp2, grp_on, off_eff;
  logic               plan_any;

  // Sequencing next-state
  always_comb begin
    st_d       = st_q;
    cfg_d      = cfg_q;
    seq_cnt_d  = seq_cnt_q;
    hold_cnt_d = hold_cnt_q;
    rel_d      = rel_q;
    if (!run) begin
      st_d       = ST_IDLE;
      seq_cnt_d  = '0;
      hold_cnt_d = '0;
      rel_d      = 1'b0;
    end else begin
      unique case (st_q)
        ST_IDLE: begin
          st_d       = ST_SETTLE;
          cfg_d      = '{sel: sel_code, par_mode: par_mode};
          seq_cnt_d  = '0;
          hold_cnt_d = '0;
        end
        ST_SETTLE: begin
          if (seq_cnt_q == SW'(CP_SETTLE_CYC - 1)) begin
            st_d      = ST_FIRST;
            seq_cnt_d = '0;
          end else begin
            seq_cnt_d = seq_cnt_q + SW'(1);
          end
        end
        ST_FIRST: begin
          if (seq_cnt_q == SW'(GROUP_GAP_CYC - 1)) begin
            st_d      = ST_BOTH;
            seq_cnt_d = '0;
          end else begin
            seq_cnt_d = seq_cnt_q + SW'(1);
          end
        end
        default: begin
          st_d = ST_BOTH;
        end
      endcase
      // Reset-release timer runs alongside the regulator sequence
      if (st_q != ST_IDLE && !rel_q) begin
        if (hold_cnt_q == RW'(RST_HOLD_CYC - 1)) begin
          rel_d = 1'b1;
        end else begin
          hold_cnt_d = hold_cnt_q + RW'(1);
        end
      end
    end
  end

  // Output next-state, registered together with the state
  always_comb begin
    grp1     = first_group(cfg_d);
    grp2     = second_group(cfg_d);
    plan_any = |(grp1 | grp2);
    grp_on   = '0;
    if (st_d == ST_FIRST || st_d == ST_BOTH) grp_on = grp_on | grp1;
    if (st_d == ST_BOTH)                     grp_on = grp_on | grp2;
    off_eff        = chan_off;
    off_eff[CH_C]  = chan_off[CH_C] & ~cfg_d.par_mode;
  end

  for (genvar i = 0; i < int'(NUM_REG); i++) begin : g_ch
    assign reg_d[i] = grp_on[i] & ~off_eff[i];
  end

  assign cp_d = ((st_d == ST_SETTLE) && plan_any) ||
                ((st_d != ST_IDLE) && (sleep_n || (|reg_d)));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q       <= ST_IDLE;
      cfg_q      <= '0;
      seq_cnt_q  <= '0;
      hold_cnt_q <= '0;
      rel_q      <= 1'b0;
      cp_q       <= 1'b0;
      reg_q      <= '0;
    end else begin
      st_q       <= st_d;
      cfg_q      <= cfg_d;
      seq_cnt_q  <= seq_cnt_d;
      hold_cnt_q <= hold_cnt_d;
      rel_q      <= rel_d;
      cp_q       <= cp_d;
      reg_q      <= reg_d;
    end
  end

  assign cp_en     = cp_q;
  assign reg_en    = reg_q;
  assign rst_out_n = rel_q;
  assign state     = st_q;
  assign cfg       = cfg_q;

endmodule

// File: rtl/pwr_seq_top.sv
module pwr_seq_top
  import pwr_seq_pkg::*;
#(
  parameter int unsigned CP_SETTLE_CYC = 1250000,
  parameter int unsigned GROUP_GAP_CYC = 200000,
  parameter int unsigned RST_HOLD_CYC  = 37500000,
  parameter int unsigned DEGLITCH_CYC  = 625,
  parameter int unsigned SYNC_STAGES   = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       supply_ok,
  input  logic       ext_rst_in,
  input  logic [1:0] sel_code,
  input  logic       par_mode,
  input  logic       sleep_n,
  input  logic [2:0] chan_off,
  output logic       cp_en,
  output logic [2:0] reg_en,
  output logic       rst_out_n,
  output logic [1:0] dbg_state
);

  logic       supply_s;
  logic       ext_rst_s;
  logic       ext_rst_filt;
  logic       run;
  seq_state_e state;
  seq_cfg_t   cfg_q;

  pwr_seq_sync #(.W(1), .STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sync_sup (
    .clk(clk), .rst_n(rst_n), .d(supply_ok), .q(supply_s)
  );

  pwr_seq_sync #(.W(1), .STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync_ext (
    .clk(clk), .rst_n(rst_n), .d(ext_rst_in), .q(ext_rst_s)
  );

  pwr_seq_deglitch #(.HOLD(DEGLITCH_CYC), .RST_LVL(1'b1)) u_dgl (
    .clk(clk), .rst_n(rst_n), .din(ext_rst_s), .dout(ext_rst_filt)
  );

  assign run = supply_s & ~ext_rst_filt;

  pwr_seq_ctrl #(
    .CP_SETTLE_CYC(CP_SETTLE_CYC),
    .GROUP_GAP_CYC(GROUP_GAP_CYC),
    .RST_HOLD_CYC (RST_HOLD_CYC)
  ) u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .run      (run),
    .sel_code (sel_code),
    .par_mode (par_mode),
    .sleep_n  (sleep_n),
    .chan_off (chan_off),
    .cp_en    (cp_en),
    .reg_en   (reg_en),
    .rst_out_n(rst_out_n),
    .state    (state),
    .cfg      (cfg_q)
  );

  assign dbg_state = state;

endmodule

// File: rtl/pwr_seq_chk.sv
module pwr_seq_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       cp_en,
  input logic [2:0] reg_en,
  input logic       rst_out_n,
  input logic [1:0] dbg_state,
  input logic [2:0] chan_off,
  input logic [2:0] cfg,
  input logic       ext_filt
);

  AST_REG_NEEDS_CP: assert property (@(posedge clk) disable iff (!rst_n)
    (|reg_en) |-> cp_en) else $error("AST_REG_NEEDS_CP"); // R10

  AST_CP_LEADS_REG: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(|reg_en) |-> $past(cp_en)) else $error("AST_CP_LEADS_REG"); // R5

  AST_BC_TOGETHER: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(reg_en[1]) && !$past(chan_off[2])) |-> reg_en[2]) else $error("AST_BC_TOGETHER"); // R12

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (dbg_state == 2'd0) |-> (!cp_en && reg_en == 3'b000 && !rst_out_n)) else $error("AST_IDLE_QUIET"); // R3

  AST_EXT_RST_STOPS: assert property (@(posedge clk) disable iff (!rst_n)
    ext_filt |=> (dbg_state == 2'd0)) else $error("AST_EXT_RST_STOPS"); // R3

  AST_CFG_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (dbg_state != 2'd0 && $past(dbg_state) != 2'd0) |-> $stable(cfg)) else $error("AST_CFG_HELD"); // R4

  AST_RELEASE_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_out_n) |-> (dbg_state != 2'd0)) else $error("AST_RELEASE_ACTIVE"); // R9

  AST_GROUND_NO_REG: assert property (@(posedge clk) disable iff (!rst_n)
    (dbg_state != 2'd0 && cfg[2:1] == 2'b00) |-> (reg_en == 3'b000)) else $error("AST_GROUND_NO_REG"); // R8

endmodule

bind pwr_seq_top pwr_seq_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .cp_en    (cp_en),
  .reg_en   (reg_en),
  .rst_out_n(rst_out_n),
  .dbg_state(dbg_state),
  .chan_off (chan_off),
  .cfg      (cfg_q),
  .ext_filt (ext_rst_filt)
);

// File: tb/tb_pwr_seq_top.sv
`timescale 1ns/1ps
module tb_pwr_seq_top;

  localparam int unsigned CPS = 40;
  localparam int unsigned GAP = 20;
  localparam int unsigned RH  = 150;
  localparam int unsigned DG  = 8;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       supply_ok;
  logic       ext_rst_in;
  logic [1:0] sel_code;
  logic       par_mode;
  logic       sleep_n;
  logic [2:0] chan_off;
  logic       cp_en;
  logic [2:0] reg_en;
  logic       rst_out_n;
  logic [1:0] dbg_state;

  always #4 clk = ~clk;  // 125 MHz

  pwr_seq_top #(
    .CP_SETTLE_CYC(CPS), .GROUP_GAP_CYC(GAP), .RST_HOLD_CYC(RH), .DEGLITCH_CYC(DG)
  ) dut (
    .clk(clk), .rst_n(rst_n), .supply_ok(supply_ok), .ext_rst_in(ext_rst_in),
    .sel_code(sel_code), .par_mode(par_mode), .sleep_n(sleep_n), .chan_off(chan_off),
    .cp_en(cp_en), .reg_en(reg_en), .rst_out_n(rst_out_n), .dbg_state(dbg_state)
  );

  typedef struct {
    int unsigned at;
    logic [4:0]  v;
    string       tag;
  } ev_t;

  ev_t         sb_q[$];
  int unsigned cyc    = 0;
  int          checks = 0;
  int          fails  = 0;
  logic        mon_on = 1'b0;
  logic [4:0]  prev_v = 5'b0;
  logic        ended  = 1'b0;

  always @(posedge clk) cyc <= cyc + 1;

  function automatic logic [4:0] cur_vec();
    return {cp_en, reg_en, rst_out_n};
  endfunction

  // Expected output vector {cp, C, B, A, rst_out_n} k cycles after start
  function automatic logic [4:0] exp_vec(int unsigned k, logic [1:0] s, logic m,
                                         logic [2:0] off, logic slp);
    logic [2:0] f, sc, r, oe;
    logic       cp;
    f = 3'b000; sc = 3'b000;
    if (s[1]) begin f = 3'b001; sc = 3'b110; end
    else if (s == 2'b01 && m) begin f = 3'b110; sc = 3'b001; end
    r = 3'b000;
    if (k >= CPS)       r = r | f;
    if (k >= CPS + GAP) r = r | sc;
    oe = off;
    if (m) oe[2] = 1'b0;
    r  = r & ~oe;
    cp = (k < CPS && (f | sc) != 3'b000) || slp || (r != 3'b000);
    return {cp, r, (k >= RH)};
  endfunction

  task automatic push_ev(int unsigned at, logic [4:0] v, string tag);
    ev_t e;
    e.at = at; e.v = v; e.tag = tag;
    sb_q.push_back(e);
  endtask

  // Driver: expected change list for a full start-up from idle at cycle s0
  task automatic push_seq(int unsigned s0, logic [1:0] s, logic m, logic [2:0] off,
                          logic slp, string tag);
    logic [4:0] p, v;
    p = 5'b0;
    for (int unsigned k = 0; k <= RH; k++) begin
      v = exp_vec(k, s, m, off, slp);
      if (v != p) push_ev(s0 + k, v, tag);
      p = v;
    end
  endtask

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // Monitor: every output change must match the next expected entry
  always @(negedge clk) begin
    if (mon_on && !ended) begin
      if (cur_vec() !== prev_v) begin
        checks++;
        if (sb_q.size() == 0) begin
          fails++;
          $display("FAIL unexpected change: actual %b at cycle %0d expected no change",
                   cur_vec(), cyc);
        end else begin
          ev_t e;
          e = sb_q.pop_front();
          if (e.v !== cur_vec() || e.at != cyc) begin
            fails++;
            $display("FAIL %s: actual %b at cycle %0d expected %b at cycle %0d",
                     e.tag, cur_vec(), cyc, e.v, e.at);
          end
        end
        prev_v = cur_vec();
      end
    end
  end

  task automatic finish_run();
    if (!ended) begin
      ended = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  task automatic wait_cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  // Drop supply and expect idle three cycles later
  task automatic supply_drop(string tag);
    @(negedge clk);
    supply_ok = 1'b0;
    push_ev(cyc + 3, 5'b0, tag);
    wait_cyc(8);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    rst_n = 1'b0; supply_ok = 1'b0; ext_rst_in = 1'b1;
    sel_code = 2'b10; par_mode = 1'b0; sleep_n = 1'b1; chan_off = 3'b000;
    wait_cyc(5);
    chk("R1 outputs in reset", {27'b0, cur_vec()}, 32'h0);
    chk("R1 state in reset", {30'b0, dbg_state}, 32'h0);
    rst_n = 1'b1;
    mon_on = 1'b1;

    // Supply good but external reset still held: stay idle
    wait_cyc(2);
    supply_ok = 1'b1;
    wait_cyc(30);
    chk("R3 held by ext reset", {25'b0, dbg_state, cur_vec()}, 32'h0);

    // Release ext reset: open strap, mode low
    @(negedge clk);
    ext_rst_in = 1'b0;
    push_seq(cyc + DG + 3, 2'b10, 1'b0, 3'b000, 1'b1, "R5 R6 R9 R12");
    wait_cyc(DG + 3 + 5);
    sel_code = 2'b00; par_mode = 1'b1;  // after capture: must be ignored
    wait_cyc(RH + 10);
    chk("R4 strap change ignored", {27'b0, cur_vec()}, 32'h1F);
    chk("R5 final state", {30'b0, dbg_state}, 32'h3);

    // Short glitch on ext reset
    @(negedge clk);
    ext_rst_in = 1'b1;
    wait_cyc(5);
    ext_rst_in = 1'b0;
    wait_cyc(25);
    chk("R2 glitch rejected", {27'b0, cur_vec()}, 32'h1F);

    // Real ext reset, then pulled-down strap with mode high
    sel_code = 2'b01; par_mode = 1'b1;
    @(negedge clk);
    ext_rst_in = 1'b1;
    push_ev(cyc + DG + 3, 5'b0, "R3 ext reset");
    wait_cyc(DG + 10);
    chk("R3 idle in ext reset", {30'b0, dbg_state}, 32'h0);
    @(negedge clk);
    ext_rst_in = 1'b0;
    push_seq(cyc + DG + 3, 2'b01, 1'b1, 3'b000, 1'b1, "R7 R12");
    wait_cyc(RH + DG + 10);

    // Pulled down, mode low: no regulators, pump follows sleep
    supply_drop("R3 supply drop");
    par_mode = 1'b0;
    @(negedge clk);
    supply_ok = 1'b1;
    push_seq(cyc + 3, 2'b01, 1'b0, 3'b000, 1'b1, "R7 R9");
    wait_cyc(RH + 10);
    chk("R7 no regulator", {29'b0, reg_en}, 32'h0);

    // Grounded strap with sleep low
    supply_drop("R3 supply drop");
    sel_code = 2'b00; sleep_n = 1'b0;
    @(negedge clk);
    supply_ok = 1'b1;
    push_seq(cyc + 3, 2'b00, 1'b0, 3'b000, 1'b0, "R8 R9 R10");
    wait_cyc(RH + 10);
    chk("R8 pump off asleep", {27'b0, cur_vec()}, 32'h01);
    @(negedge clk);
    sleep_n = 1'b1;
    push_ev(cyc + 1, 5'b10001, "R10 wake");
    wait_cyc(5);

    // Open strap, C held off with mode low
    supply_drop("R3 supply drop");
    sel_code = 2'b10; par_mode = 1'b0; chan_off = 3'b100;
    @(negedge clk);
    supply_ok = 1'b1;
    push_seq(cyc + 3, 2'b10, 1'b0, 3'b100, 1'b1, "R11 R6");
    wait_cyc(RH + 10);
    @(negedge clk);
    chan_off = 3'b101;
    push_ev(cyc + 1, 5'b10101, "R11 live off A");
    wait_cyc(4);
    @(negedge clk);
    chan_off = 3'b111; sleep_n = 1'b0;
    push_ev(cyc + 1, 5'b00001, "R10 R11 all off asleep");
    wait_cyc(4);
    chk("R10 pump stopped", {31'b0, cp_en}, 32'h0);

    // Open strap, mode high: C off bit ignored
    supply_drop("R3 supply drop");
    par_mode = 1'b1; chan_off = 3'b100; sleep_n = 1'b1;
    @(negedge clk);
    supply_ok = 1'b1;
    push_seq(cyc + 3, 2'b10, 1'b1, 3'b100, 1'b1, "R11 R6 R12");
    wait_cyc(RH + 10);
    chk("R11 C bit ignored", {29'b0, reg_en}, 32'h7);

    chk("R5 all expected changes seen", sb_q.size(), 32'h0);
    finish_run();
  end

endmodule